// File: doc/BRIEF.md
# Latched Interrupt Status Controller

This block gathers one-cycle event pulses from a set of sources into sticky status bits. The bits stay set until software clears them with a write-one-to-clear access. A single active-high interrupt line is raised while any status bit is set and its mask bit is zero. Masked bits still latch, so software can poll them. A separate read-only sense register shows the live level of each source. It is never latched and cannot be cleared.

Register accesses arrive on a plain synchronous bus: address, write enable, write data, and a combinational read-data return. Each of the three registers has its own address. At reset every source is masked except the low-power-boot source. Clearing a mask bit whose status bit is already set raises the interrupt on the clock edge that takes the write. When an event and a clear of the same bit fall in the same cycle, the event wins.

Top module: `irq_latch_ctrl`

## Requirements
- R1: `irq_o` is 1 exactly when some status bit is 1 and its mask bit is 0. It follows the registers with no extra delay.
- R2: An event pulse on `evt_i[k]` sets status bit k at the next rising clock edge. The bit stays 1 after the pulse ends until software clears it.
- R3: A write to address 0 (status) with a 1 in position k clears status bit k. Once no set, unmasked bit remains, `irq_o` returns to 0.
- R4: A 0 in any position of a status write leaves that status bit unchanged.
- R5: A status bit whose event and clear land on the same clock edge remains 1. An event on another bit during a clear write keeps `irq_o` at 1.
- R6: While mask bit k is 1, an event on k still sets status bit k, which can be read at address 0, and `irq_o` stays 0.
- R7: A write to address 1 (mask) takes effect at the next clock edge. Clearing a mask bit whose status bit is 1 drives `irq_o` to 1 right after that edge.
- R8: After reset, status is all zero, `irq_o` is 0, and the mask is all ones except bit `BOOT_SRC` (default 9), which is 0. With 16 sources the mask reads 16'hFDFF.
- R9: A read at address 2 (sense) returns `sense_i` as it is in that cycle. Writes to address 2 change neither status, mask nor `irq_o`.
- R10: Sense bits [9:8] carry the charger-fault code unchanged: 00 no fault, 01 charge-source fault, 10 battery fault, 11 battery-temperature fault.
- R11: A read at address 3 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| evt_i | input | NUM_SRC | One-cycle event pulses, one per source |
| sense_i | input | NUM_SRC | Live source levels |
| reg_addr_i | input | 2 | Register address: 0 status, 1 mask, 2 sense, 3 unused |
| reg_we_i | input | 1 | Write enable |
| reg_wdata_i | input | NUM_SRC | Write data |
| reg_rdata_o | output | NUM_SRC | Read data for the addressed register |
| irq_o | output | 1 | Shared active-high interrupt |

## Verification
The bench targets four hazards:
- An event that lands in the same cycle as a clear of its own bit. A design that gives the clear priority loses that event.
- An event on another bit during a clear. A design that drops the interrupt for a cycle, or wipes the whole register, fails here.
- Unmasking a bit that latched while masked. A design that only raises the interrupt on new events never asserts the line.
- The reset mask pattern, the write-zero case and writes to the sense address. A wrong boot mask, a plain write instead of write-one-to-clear, or a sense write that leaks into status or mask all show up as wrong read-back values or a wrong interrupt level.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned REG_ADDR_W = 2;
  localparam logic [REG_ADDR_W-1:0] ADDR_STATUS = 2'd0;
  localparam logic [REG_ADDR_W-1:0] ADDR_MASK   = 2'd1;
  localparam logic [REG_ADDR_W-1:0] ADDR_SENSE  = 2'd2;
  localparam logic [REG_ADDR_W-1:0] ADDR_SPARE  = 2'd3;

  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_MASK   = 2'd1,
    SEL_SENSE  = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irqc_rst_sync.sv
module irqc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/irqc_status_bank.sv
module irqc_status_bank #(
  parameter int unsigned NUM_SRC = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic               clr_en_i,
  input  logic [NUM_SRC-1:0] clr_bits_i,
  output logic [NUM_SRC-1:0] stat_o
);
  logic [NUM_SRC-1:0] stat_q;
  logic [NUM_SRC-1:0] stat_d;
  logic [NUM_SRC-1:0] bit_en;

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_bit
    logic clr_k;

    // Set wins over clear when both land in the same cycle.
    always_comb begin
      clr_k     = clr_en_i & clr_bits_i[k];
      bit_en[k] = set_i[k] | clr_k;
      stat_d[k] = set_i[k] | (stat_q[k] & ~clr_k);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stat_q[k] <= 1'b0;
      end else if (bit_en[k]) begin
        stat_q[k] <= stat_d[k];
      end
    end
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/irqc_mask_reg.sv
module irqc_mask_reg #(
  parameter int unsigned NUM_SRC  = 16,
  parameter int unsigned BOOT_SRC = 9
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [NUM_SRC-1:0] wr_data_i,
  output logic [NUM_SRC-1:0] mask_o
);
  localparam logic [NUM_SRC-1:0] MASK_RST = ~(NUM_SRC'(1) << BOOT_SRC);

  logic [NUM_SRC-1:0] mask_q;
  logic [NUM_SRC-1:0] mask_d;

  always_comb begin
    mask_d = wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= MASK_RST;
    end else if (wr_en_i) begin
      mask_q <= mask_d;
    end
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/irqc_read_mux.sv
module irqc_read_mux
  import irqc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 16
) (
  input  logic [REG_ADDR_W-1:0] addr_i,
  input  logic [NUM_SRC-1:0]    stat_i,
  input  logic [NUM_SRC-1:0]    mask_i,
  input  logic [NUM_SRC-1:0]    sense_i,
  output logic [NUM_SRC-1:0]    rdata_o
);
  reg_sel_e sel;

  always_comb begin
    sel = reg_sel_e'(addr_i);
    unique case (sel)
      SEL_STATUS: rdata_o = stat_i;
      SEL_MASK:   rdata_o = mask_i;
      SEL_SENSE:  rdata_o = sense_i;
      default:    rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/irq_latch_ctrl.sv
module irq_latch_ctrl
  import irqc_pkg::*;
#(
  parameter int unsigned NUM_SRC  = 16,
  parameter int unsigned BOOT_SRC = 9
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_SRC-1:0]    evt_i,
  input  logic [NUM_SRC-1:0]    sense_i,
  input  logic [REG_ADDR_W-1:0] reg_addr_i,
  input  logic                  reg_we_i,
  input  logic [NUM_SRC-1:0]    reg_wdata_i,
  output logic [NUM_SRC-1:0]    reg_rdata_o,
  output logic                  irq_o
);
  logic               rst_n_sync;
  logic               stat_wr;
  logic               mask_wr;
  logic [NUM_SRC-1:0] stat_q;
  logic [NUM_SRC-1:0] mask_q;
  logic [NUM_SRC-1:0] pending;

  always_comb begin
    stat_wr = reg_we_i && (reg_addr_i == ADDR_STATUS);
    mask_wr = reg_we_i && (reg_addr_i == ADDR_MASK);
  end

  irqc_rst_sync #(.STAGES(2)) u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_sync)
  );

  irqc_status_bank #(.NUM_SRC(NUM_SRC)) u_stat (
    .clk_i      (clk_i),
    .rst_ni     (rst_n_sync),
    .set_i      (evt_i),
    .clr_en_i   (stat_wr),
    .clr_bits_i (reg_wdata_i),
    .stat_o     (stat_q)
  );

  irqc_mask_reg #(.NUM_SRC(NUM_SRC), .BOOT_SRC(BOOT_SRC)) u_mask (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_sync),
    .wr_en_i   (mask_wr),
    .wr_data_i (reg_wdata_i),
    .mask_o    (mask_q)
  );

  irqc_read_mux #(.NUM_SRC(NUM_SRC)) u_rd (
    .addr_i  (reg_addr_i),
    .stat_i  (stat_q),
    .mask_i  (mask_q),
    .sense_i (sense_i),
    .rdata_o (reg_rdata_o)
  );

  always_comb begin
    pending = stat_q & ~mask_q;
    irq_o   = |pending;
  end
endmodule

// File: rtl/irq_latch_ctrl_chk.sv
module irq_latch_ctrl_chk
  import irqc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 16
) (
  input logic                  clk_i,
  input logic                  rst_n,
  input logic [NUM_SRC-1:0]    evt_i,
  input logic [NUM_SRC-1:0]    sense_i,
  input logic [REG_ADDR_W-1:0] reg_addr_i,
  input logic                  reg_we_i,
  input logic [NUM_SRC-1:0]    reg_wdata_i,
  input logic [NUM_SRC-1:0]    reg_rdata_o,
  input logic                  irq_o,
  input logic [NUM_SRC-1:0]    stat_q,
  input logic [NUM_SRC-1:0]    mask_q
);
  logic swr;
  logic mwr;
  assign swr = reg_we_i && (reg_addr_i == ADDR_STATUS);
  assign mwr = reg_we_i && (reg_addr_i == ADDR_MASK);

  assert_latch_R2: assert property (@(posedge clk_i) disable iff (!rst_n)
    (|evt_i) |=> ((stat_q & $past(evt_i)) == $past(evt_i)));

  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_n)
    !swr |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

  assert_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_n)
    swr |=> ((stat_q & $past(reg_wdata_i) & ~$past(evt_i)) == '0));

  assert_keep_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_n)
    swr |=> ((stat_q & $past(stat_q) & ~$past(reg_wdata_i))
             == ($past(stat_q) & ~$past(reg_wdata_i))));

  assert_set_wins_R5: assert property (@(posedge clk_i) disable iff (!rst_n)
    (swr && (|evt_i)) |=> ((stat_q & $past(evt_i)) == $past(evt_i)));

  assert_mask_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_n)
    !mwr |=> $stable(mask_q));

  assert_irq_rise_R1: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(irq_o) |-> ($past(|evt_i) || $past(mwr)));

  assert_irq_fall_R3: assert property (@(posedge clk_i) disable iff (!rst_n)
    $fell(irq_o) |-> ($past(swr) || $past(mwr)));

  assert_sense_R9: assert property (@(posedge clk_i) disable iff (!rst_n)
    (reg_addr_i == ADDR_SENSE) |-> (reg_rdata_o == sense_i));

  assert_spare_R11: assert property (@(posedge clk_i) disable iff (!rst_n)
    (reg_addr_i == ADDR_SPARE) |-> (reg_rdata_o == '0));
endmodule

bind irq_latch_ctrl irq_latch_ctrl_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk_i       (clk_i),
  .rst_n       (rst_n_sync),
  .evt_i       (evt_i),
  .sense_i     (sense_i),
  .reg_addr_i  (reg_addr_i),
  .reg_we_i    (reg_we_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .irq_o       (irq_o),
  .stat_q      (stat_q),
  .mask_q      (mask_q)
);

// File: tb/irq_latch_ctrl_test.sv
module irq_latch_ctrl_test;
  localparam int N = 16;

  logic         clk;
  logic         rst_ni;
  logic [N-1:0] evt;
  logic [N-1:0] sense;
  logic [1:0]   addr;
  logic         we;
  logic [N-1:0] wdata;
  logic [N-1:0] rdata;
  logic         irq;

  int n_chk;
  int n_fail;
  bit done;

  irq_latch_ctrl #(.NUM_SRC(N), .BOOT_SRC(9)) uut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .evt_i       (evt),
    .sense_i     (sense),
    .reg_addr_i  (addr),
    .reg_we_i    (we),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .irq_o       (irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    check(act == exp, req, act, exp);
  endtask

  task automatic rd(input logic [1:0] a, output logic [N-1:0] v);
    @(negedge clk);
    addr = a;
    #1;
    v = rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [N-1:0] d, input logic [N-1:0] e);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1; evt = e;
    @(negedge clk);
    we = 1'b0; evt = '0; wdata = '0;
  endtask

  task automatic pulse(input logic [N-1:0] e);
    @(negedge clk);
    evt = e;
    @(negedge clk);
    evt = '0;
  endtask

  task automatic t_reset();
    logic [N-1:0] v;
    rd(2'd0, v); chk_eq("R8 status after reset", v, 16'h0000);
    rd(2'd1, v); chk_eq("R8 mask after reset", v, 16'hFDFF);
    chk_eq("R8 irq after reset", irq, 1'b0);
    pulse(16'h0001);
    chk_eq("R8 masked source 0 no irq", irq, 1'b0);
    pulse(16'h0200);
    chk_eq("R8 boot source unmasked", irq, 1'b1);
    wr(2'd0, 16'h0201, '0);
    chk_eq("R3 cleared after boot test", irq, 1'b0);
    wr(2'd1, 16'h0000, '0);
  endtask

  task automatic t_latch();
    logic [N-1:0] v;
    pulse(16'h0008);
    chk_eq("R2 irq after event", irq, 1'b1);
    repeat (3) @(negedge clk);
    rd(2'd0, v); chk_eq("R2 status held", v, 16'h0008);
    chk_eq("R1 irq held", irq, 1'b1);
  endtask

  task automatic t_clear();
    logic [N-1:0] v;
    wr(2'd0, 16'h0008, '0);
    rd(2'd0, v); chk_eq("R3 status cleared", v, 16'h0000);
    chk_eq("R3 irq low", irq, 1'b0);
  endtask

  task automatic t_write_zero();
    logic [N-1:0] v;
    pulse(16'h0022);
    wr(2'd0, 16'h0000, '0);
    rd(2'd0, v); chk_eq("R4 zero write no change", v, 16'h0022);
    wr(2'd0, 16'h0002, '0);
    rd(2'd0, v); chk_eq("R4 partial clear", v, 16'h0020);
    chk_eq("R1 irq with one left", irq, 1'b1);
    wr(2'd0, 16'h0020, '0);
    chk_eq("R3 irq low after last", irq, 1'b0);
  endtask

  task automatic t_set_priority();
    logic [N-1:0] v;
    pulse(16'h0010);
    wr(2'd0, 16'h0010, 16'h0010);
    rd(2'd0, v); chk_eq("R5 same-bit set wins", v, 16'h0010);
    wr(2'd0, 16'h0010, 16'h0080);
    rd(2'd0, v); chk_eq("R5 other event during clear", v, 16'h0080);
    chk_eq("R5 irq stays high", irq, 1'b1);
    wr(2'd0, 16'h0080, '0);
  endtask

  task automatic t_masked_unmask();
    logic [N-1:0] v;
    wr(2'd1, 16'h0004, '0);
    pulse(16'h0004);
    rd(2'd0, v); chk_eq("R6 masked bit latched", v, 16'h0004);
    chk_eq("R6 masked no irq", irq, 1'b0);
    @(negedge clk);
    addr = 2'd1; wdata = 16'h0000; we = 1'b1;
    #1; chk_eq("R7 mask not yet applied", irq, 1'b0);
    @(negedge clk);
    we = 1'b0;
    chk_eq("R7 unmask raises irq", irq, 1'b1);
    wr(2'd0, 16'h0004, '0);
    chk_eq("R3 irq low after unmask clear", irq, 1'b0);
  endtask

  task automatic t_sense();
    logic [N-1:0] v;
    sense = 16'h1234;
    rd(2'd2, v); chk_eq("R9 sense live", v, 16'h1234);
    sense = 16'h00A5;
    rd(2'd2, v); chk_eq("R9 sense follows input", v, 16'h00A5);
    pulse(16'h0040);
    wr(2'd2, 16'hFFFF, '0);
    rd(2'd0, v); chk_eq("R9 sense write status kept", v, 16'h0040);
    rd(2'd1, v); chk_eq("R9 sense write mask kept", v, 16'h0000);
    chk_eq("R9 sense write irq kept", irq, 1'b1);
    rd(2'd2, v); chk_eq("R9 sense unchanged by write", v, 16'h00A5);
    wr(2'd0, 16'h0040, '0);
    sense = 16'h0200;
    rd(2'd2, v); chk_eq("R10 battery fault code", {30'd0, v[9:8]}, 32'd2);
    sense = 16'h0300;
    rd(2'd2, v); chk_eq("R10 temperature fault code", {30'd0, v[9:8]}, 32'd3);
    sense = 16'h0100;
    rd(2'd2, v); chk_eq("R10 source fault code", {30'd0, v[9:8]}, 32'd1);
  endtask

  task automatic t_spare();
    logic [N-1:0] v;
    pulse(16'hFFFF);
    rd(2'd0, v); chk_eq("R2 all sources latch", v, 16'hFFFF);
    rd(2'd3, v); chk_eq("R11 spare reads zero", v, 16'h0000);
    wr(2'd0, 16'hFFFF, '0);
    chk_eq("R3 all cleared irq low", irq, 1'b0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    n_chk = 0; n_fail = 0; done = 1'b0;
    rst_ni = 1'b0; evt = '0; sense = '0; addr = '0; we = 1'b0; wdata = '0;
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_latch();
    t_clear();
    t_write_zero();
    t_set_priority();
    t_masked_unmask();
    t_sense();
    t_spare();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      summary();
      $finish;
    end
  end
endmodule